// File: doc/BRIEF.md
# Matrix Keypad Scanner with Press/Acknowledge Handshake

This block scans a 4 x 4 key matrix by pulling one column low at a time and reading the active-low row lines back through a two-stage synchroniser. Each column is held for a fixed dwell time, so the synchronised rows settle before they are judged. At the end of a dwell, a small computed table is addressed by the binary column number joined with the active row pattern. The table returns a 4-bit key code and a valid bit.

When the valid bit is seen, the scanner stops stepping, registers the code and raises a press flag. Flag and code stay frozen until the consumer pulses an acknowledge. The scanner then drives every column low and waits until no row has been active for a set number of consecutive cycles. Only then does it resume scanning from column 0. This both debounces the release and stops a held key from repeating.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and after it, with no key held, `key_press_o` is 0, `key_code_o` is 0 and `col_n_o` is 4'b1110 (column 0 driven low).
- R2: While scanning, exactly one bit of `col_n_o` is low. The driven column index rises by one (wrapping from 3 to 0) every DWELL (default 4) cycles.
- R3: A single held key at row r (bit r of `row_n_i`) and column c (bit c of `col_n_o`) yields `key_code_o` = 4*r + c.
- R4: A single held key raises `key_press_o` within NCOLS*DWELL + 4 cycles of being pressed.
- R5: While `key_press_o` is high, `key_code_o` and `col_n_o` do not change.
- R6: `key_press_o` stays high until `key_ack_i` is sampled high. It is low on the cycle after that acknowledge.
- R7: When a column reads two or more active rows, no press is reported.
- R8: After an acknowledge, `col_n_o` is all zeros and no new press is reported while any row is active. Scanning resumes (a column goes high) between REL_CYCLES and REL_CYCLES+4 cycles after every key is released.
- R9: An acknowledge pulse that arrives while no press is pending has no effect: no press appears, and a later key is reported normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n_i | input | 4 | Row lines from the matrix, active low, asynchronous |
| key_ack_i | input | 1 | Consumer acknowledge, synchronous pulse |
| col_n_o | output | 4 | Column drive, active low |
| key_code_o | output | 4 | Registered code of the captured key |
| key_press_o | output | 1 | Key captured and waiting for acknowledge |

## Verification
A press becomes visible one clock after the end of the dwell that sees it. That is up to one full scan round plus the two synchroniser stages later, so the bench polls for it inside an NCOLS*DWELL + 4 cycle window. The press flag must drop exactly one cycle after the acknowledge, and the bench samples it on the next falling edge. After a release, rows need two cycles to reach the controller and then REL_CYCLES idle cycles, so the resume check accepts a short window rather than a single cycle. A scoreboard queue records the expected code at each key press, and the monitor compares it on each rising press flag.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_HAVE = 2'd1,
        ST_REL  = 2'd2
    } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '1;
                end else if (s == 0) begin
                    stg_q[s] <= d_i;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kp_code_rom.sv
module kp_code_rom #(
    parameter int NCOLS  = 4,
    parameter int NROWS  = 4,
    parameter int CODE_W = 4,
    localparam int CW    = $clog2(NCOLS)
) (
    input  logic [CW-1:0]    col_i,
    input  logic [NROWS-1:0] rows_act_i,
    output logic [CODE_W:0]  entry_o
);
    // Table addressed by {column, active rows}; computed rather than stored.
    always_comb begin
        int hits;
        int row_idx;
        hits    = 0;
        row_idx = 0;
        for (int r = 0; r < NROWS; r++) begin
            if (rows_act_i[r]) begin
                hits    = hits + 1;
                row_idx = r;
            end
        end
        entry_o[CODE_W]     = (hits == 1);
        entry_o[CODE_W-1:0] = (hits == 1) ? CODE_W'(row_idx * NCOLS + int'(col_i)) : '0;
    end
endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
    import kp_pkg::*;
#(
    parameter int NCOLS      = 4,
    parameter int NROWS      = 4,
    parameter int CODE_W     = 4,
    parameter int DWELL      = 4,
    parameter int REL_CYCLES = 16,
    localparam int CW        = $clog2(NCOLS),
    localparam int DW        = $clog2(DWELL),
    localparam int RW        = $clog2(REL_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NROWS-1:0]  rows_act_i,
    input  logic [CODE_W:0]   entry_i,
    input  logic              ack_i,
    output logic [CW-1:0]     col_o,
    output logic              drive_all_o,
    output logic [CODE_W-1:0] code_o,
    output logic              press_o
);
    localparam logic [CW-1:0] COL_LAST   = CW'(NCOLS - 1);
    localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL - 1);
    localparam logic [RW-1:0] REL_LAST   = RW'(REL_CYCLES - 1);

    typedef struct packed {
        kp_state_e         state;
        logic [CW-1:0]     col;
        logic [DW-1:0]     dwell;
        logic [RW-1:0]     rel;
        logic [CODE_W-1:0] code;
        logic              press;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_SCAN: begin
                if (st_q.dwell == DWELL_LAST) begin
                    st_d.dwell = '0;
                    if (entry_i[CODE_W]) begin
                        st_d.state = ST_HAVE;
                        st_d.code  = entry_i[CODE_W-1:0];
                        st_d.press = 1'b1;
                    end else begin
                        st_d.col = (st_q.col == COL_LAST) ? '0 : st_q.col + 1'b1;
                    end
                end else begin
                    st_d.dwell = st_q.dwell + 1'b1;
                end
            end
            ST_HAVE: begin
                if (ack_i) begin
                    st_d.state = ST_REL;
                    st_d.press = 1'b0;
                    st_d.rel   = '0;
                end
            end
            ST_REL: begin
                if (|rows_act_i) begin
                    st_d.rel = '0;
                end else if (st_q.rel == REL_LAST) begin
                    st_d.state = ST_SCAN;
                    st_d.col   = '0;
                    st_d.dwell = '0;
                end else begin
                    st_d.rel = st_q.rel + 1'b1;
                end
            end
            default: st_d.state = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_SCAN, col: '0, dwell: '0, rel: '0, code: '0, press: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o       = st_q.col;
    assign drive_all_o = (st_q.state == ST_REL);
    assign code_o      = st_q.code;
    assign press_o     = st_q.press;
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int NCOLS      = 4,
    parameter int NROWS      = 4,
    parameter int CODE_W     = 4,
    parameter int DWELL      = 4,
    parameter int REL_CYCLES = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NROWS-1:0]  row_n_i,
    input  logic              key_ack_i,
    output logic [NCOLS-1:0]  col_n_o,
    output logic [CODE_W-1:0] key_code_o,
    output logic              key_press_o
);
    localparam int CW = $clog2(NCOLS);

    logic [NROWS-1:0] row_n_s;
    logic [NROWS-1:0] rows_act;
    logic [CODE_W:0]  entry;
    logic [CW-1:0]    col_idx;
    logic             drive_all;

    kp_sync #(.W(NROWS), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (row_n_i),
        .q_o   (row_n_s)
    );

    assign rows_act = ~row_n_s;

    kp_code_rom #(.NCOLS(NCOLS), .NROWS(NROWS), .CODE_W(CODE_W)) u_rom (
        .col_i      (col_idx),
        .rows_act_i (rows_act),
        .entry_o    (entry)
    );

    kp_ctrl #(
        .NCOLS(NCOLS), .NROWS(NROWS), .CODE_W(CODE_W),
        .DWELL(DWELL), .REL_CYCLES(REL_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rows_act_i  (rows_act),
        .entry_i     (entry),
        .ack_i       (key_ack_i),
        .col_o       (col_idx),
        .drive_all_o (drive_all),
        .code_o      (key_code_o),
        .press_o     (key_press_o)
    );

    always_comb begin
        for (int c = 0; c < NCOLS; c++) begin
            col_n_o[c] = drive_all ? 1'b0 : (CW'(c) != col_idx);
        end
    end
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk #(
    parameter int NCOLS  = 4,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCOLS-1:0]  col_n_o,
    input logic [CODE_W-1:0] key_code_o,
    input logic              key_press_o,
    input logic              key_ack_i
);
    a_r5_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (key_press_o && $past(key_press_o)) |-> $stable(key_code_o));

    a_r5_col_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (key_press_o && $past(key_press_o)) |-> $stable(col_n_o));

    a_r2_one_col_on_press: assert property (@(posedge clk) disable iff (!rst_n)
        key_press_o |-> ($countones(~col_n_o) == 1));

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (key_press_o && !key_ack_i) |=> key_press_o);

    a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (key_press_o && key_ack_i) |=> !key_press_o);

    a_r8_all_cols_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_press_o) |-> (col_n_o == '0));
endmodule

bind keypad_scanner kp_scanner_chk #(.NCOLS(NCOLS), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_n_o     (col_n_o),
    .key_code_o  (key_code_o),
    .key_press_o (key_press_o),
    .key_ack_i   (key_ack_i)
);

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    localparam int NC    = 4;
    localparam int NR    = 4;
    localparam int DWELL = 4;
    localparam int REL   = 16;
    localparam int PRESS_LIMIT = NC*DWELL + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] row_n;
    logic          ack = 1'b0;
    logic [NC-1:0] col_n;
    logic [3:0]    code;
    logic          press;
    logic [NR*NC-1:0] key_mat = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [3:0] exp_q[$];
    logic prev_press = 1'b0;

    always #10 clk = ~clk;

    keypad_scanner #(.NCOLS(NC), .NROWS(NR), .CODE_W(4), .DWELL(DWELL), .REL_CYCLES(REL)) dut (
        .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .key_ack_i(ack),
        .col_n_o(col_n), .key_code_o(code), .key_press_o(press)
    );

    // Matrix model: a held key connects its column drive to its row line.
    always_comb begin
        for (int r = 0; r < NR; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < NC; c++)
                if (key_mat[r*NC+c] && !col_n[c]) row_n[r] = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: hold a key and push its expected code into the scoreboard
    task automatic hold_key(input int r, input int c);
        key_mat[r*NC+c] = 1'b1;
        exp_q.push_back(4'(r*NC + c));
    endtask

    task automatic wait_press(input string req);
        int n = 0;
        while (!press && n < PRESS_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(press == 1'b1, req, n, PRESS_LIMIT);
    endtask

    task automatic ack_and_release(input bit release_first);
        int n;
        logic [NC-1:0] col_held;
        col_held = col_n;
        repeat (8) begin
            @(negedge clk);
            check(press == 1'b1, "R6", press, 1);
            check(col_n == col_held, "R5", col_n, col_held);
        end
        if (release_first) key_mat = '0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(press == 1'b0, "R6", press, 0);
        check(col_n == '0, "R8", col_n, 0);
        if (!release_first) begin
            repeat (40) @(negedge clk);
            check(press == 1'b0, "R8", press, 0);
            check(col_n == '0, "R8", col_n, 0);
            key_mat = '0;
        end
        n = 0;
        while (col_n == '0 && n < REL + 10) begin
            @(negedge clk);
            n++;
        end
        if (!release_first)
            check(n >= REL && n <= REL + 4, "R8", n, REL);
        else
            check(col_n == 4'b1110, "R8", col_n, 4'b1110);
        check(press == 1'b0, "R8", press, 0);
    endtask

    // Monitor: compare each newly reported key against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (press && !prev_press) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R9 unexpected press", int'(code), -1);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(code == e, "R3", code, e);
                end
            end
            prev_press <= press;
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(press == 1'b0, "R1", press, 0);
        check(code == 4'd0, "R1", code, 0);
        check(col_n == 4'b1110, "R1", col_n, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(press == 1'b0, "R1", press, 0);

        // R2 column stepping: skip first run, then check run lengths and order
        begin
            int prev_idx, run;
            bool_seen: begin end
            while (col_n == 4'b1110) @(negedge clk);
            prev_idx = 1; run = 1;
            for (int k = 0; k < 6*DWELL; k++) begin
                @(negedge clk);
                check($countones(~col_n) == 1, "R2", col_n, 1);
                if (col_n != ~(4'b1 << prev_idx)) begin
                    check(run == DWELL, "R2", run, DWELL);
                    check(col_n == ~(4'b1 << ((prev_idx + 1) % NC)), "R2", col_n,
                          ~(4'b1 << ((prev_idx + 1) % NC)));
                    prev_idx = (prev_idx + 1) % NC;
                    run = 1;
                end else begin
                    run++;
                end
            end
        end

        // R3/R4/R5/R6/R8: several keys, held through ack then released
        hold_key(1, 2);
        wait_press("R4");
        check(col_n == 4'b1011, "R5", col_n, 4'b1011);
        ack_and_release(1'b0);

        hold_key(0, 0);
        wait_press("R4");
        ack_and_release(1'b0);

        hold_key(3, 3);
        wait_press("R4");
        ack_and_release(1'b1);

        hold_key(2, 1);
        wait_press("R4");
        ack_and_release(1'b0);

        // R7: two rows in the same column -> no press
        key_mat[0*NC+2] = 1'b1;
        key_mat[3*NC+2] = 1'b1;
        repeat (3*NC*DWELL) @(negedge clk);
        check(press == 1'b0, "R7", press, 0);
        key_mat = '0;
        repeat (4) @(negedge clk);

        // R9: stray acknowledge while scanning is ignored
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (2) @(negedge clk);
        check(press == 1'b0, "R9", press, 0);
        check($countones(~col_n) == 1, "R9", col_n, 1);
        hold_key(3, 0);
        wait_press("R9");
        ack_and_release(1'b0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule